// File: doc/BRIEF.md
# Fractional-N PLL feedback divider

This block is the digital part of the feedback path in a clock-synthesis PLL. It runs on the VCO output clock. It emits one pulse per feedback period, and that pulse goes to the phase comparator. The period is a whole number of VCO cycles set by a 4-bit ratio code. In fractional mode, a first-order accumulator adds the fraction word K once per period. Each time the accumulator overflows, that period is stretched by one ratio step, so the long-run ratio becomes N + K/2^FRAC_W. An optional divide-by-4 in the feedback path multiplies every period by four, which lets the loop lock to slow references. A separate prescaler on the reference clock can divide the reference by 2 or 4, or pass every reference cycle through.

Software programs the block through one 16-bit control word. Every write replaces the whole control register. It also stores the 4-bit data field into the nibble of K that the 3-bit page field selects. A new ratio, a new fraction or a new mode never cuts the running period short: the counter takes on new settings only as a period ends.

Top module: `fracn_fb_div`

## Requirements
- R1: The control register resets to all zeros, and each write replaces it whole. Its fields are: ratio code at bits 15:12, feedback divide-by-4 enable at bit 11, fractional enable at bit 10, reference prescaler enable at bit 9, prescaler select at bit 8 (0 = /2, 1 = /4), page at bits 6:4, page data at bits 3:0. Bit 7 is stored but has no effect.
- R2: The fraction K (FRAC_W bits) resets to zero. On each write, page p places data bits into K[4p+3:4p], clipped at bit FRAC_W-1. Pages that lie wholly above K are ignored: with FRAC_W=22 that is pages 6 and 7, and page 5 keeps only its low 2 bits.
- R3: With the fractional enable at 0 and the feedback divide-by-4 off, each feedback period lasts exactly R VCO cycles. R is the ratio code clamped to the range 5 to 12, so codes 0 to 4 divide by 5 and codes 13 to 15 divide by 12.
- R4: With the fractional enable at 1, each period lasts R or R+1 base cycles. Over any 2^FRAC_W consecutive periods with fixed settings, the total is exactly (R·2^FRAC_W + K) base cycles.
- R5: With the feedback divide-by-4 enabled, every period, integer or fractional, is four times its base length. Ratio code 12 then gives 48 VCO cycles.
- R6: Settings written during a period do not change that period's length. They take effect from the next period.
- R7: fb_tick is high for exactly one VCO cycle at the end of each period.
- R8: ref_tick, in the reference clock domain, is high every reference cycle when the prescaler is off. It is high every 2nd cycle when the prescaler is on with select 0, and every 4th cycle with select 1.
- R9: With the fractional enable at 0, K has no effect on the ratio and the accumulator holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | VCO output clock |
| ref_clk | input | 1 | Reference input clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| wr_en | input | 1 | Control-word write strobe (clk domain) |
| wr_data | input | 16 | Control word to write |
| fb_tick | output | 1 | One-cycle pulse at each feedback period end (clk domain) |
| ref_tick | output | 1 | Prescaled reference pulse (ref_clk domain) |
| cfg_q | output | 16 | Current control register |
| frac_q | output | FRAC_W | Current fraction word K |

## Verification
On every cycle, the checker confirms the following: fb_tick never stays high for two cycles; the loaded period length stays within 5 to 52 and changes only at a period end; the accumulator stays frozen in integer mode; and ref_tick fires on every cycle while the prescaler is bypassed. The bench scenarios are the only place that show the actual lengths: clamping of out-of-range ratio codes, the divide-by-4 multiplier, the exact cycle total of the fractional average over a full accumulator cycle, the page write and page-ignore rules, and the fact that a write in mid-period leaves that period intact. The /2 and /4 reference spacings are also shown only by the bench.

// File: rtl/fracn_fb_div_pkg.sv
package fracn_fb_div_pkg;
  localparam int N_MIN  = 5;
  localparam int N_MAX  = 12;
  localparam int LF_MUL = 4;
  localparam int CNT_W  = $clog2((N_MAX + 1) * LF_MUL + 1);

  typedef struct packed {
    logic [3:0] ratio;
    logic       lf_div4;
    logic       frac_en;
    logic       pre_en;
    logic       pre_sel;
    logic       spare;
    logic [2:0] page;
    logic [3:0] pdata;
  } cfg_t;
endpackage

// File: rtl/fracn_cfg_regs.sv
module fracn_cfg_regs #(
  parameter int FRAC_W = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [15:0]       wr_data,
  output logic [15:0]       ctrl_q,
  output logic [FRAC_W-1:0] frac_q
);
  logic [15:0]       ctrl_d;
  logic [FRAC_W-1:0] frac_d;

  always_comb begin
    ctrl_d = ctrl_q;
    frac_d = frac_q;
    if (wr_en) begin
      ctrl_d = wr_data;
      for (int b = 0; b < FRAC_W; b++) begin
        if ((b / 4) == int'(wr_data[6:4])) frac_d[b] = wr_data[b % 4];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      frac_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      frac_q <= frac_d;
    end
  end
endmodule

// File: rtl/fracn_sdm_accum.sv
module fracn_sdm_accum #(
  parameter int FRAC_W = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  logic [FRAC_W-1:0] frac_k,
  output logic              carry,
  output logic [FRAC_W-1:0] acc_q
);
  logic [FRAC_W:0]   sum;
  logic [FRAC_W-1:0] acc_d;

  always_comb begin
    sum   = {1'b0, acc_q} + {1'b0, frac_k};
    carry = sum[FRAC_W];
    acc_d = step_en ? sum[FRAC_W-1:0] : acc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end
endmodule

// File: rtl/fracn_fb_counter.sv
module fracn_fb_counter
  import fracn_fb_div_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       ratio,
  input  logic             lf_div4,
  input  logic             stretch,
  output logic             period_end,
  output logic [CNT_W-1:0] len_cur,
  output logic             fb_tick
);
  logic [CNT_W-1:0] cnt_q, cnt_d, len_d, len_new, base;
  logic [3:0]       n_clamp;

  always_comb begin
    if (int'(ratio) < N_MIN)      n_clamp = 4'(N_MIN);
    else if (int'(ratio) > N_MAX) n_clamp = 4'(N_MAX);
    else                          n_clamp = ratio;
    base       = CNT_W'(n_clamp) + CNT_W'(stretch);
    len_new    = lf_div4 ? (base << 2) : base;
    period_end = (cnt_q == len_cur - CNT_W'(1));
    cnt_d      = period_end ? '0 : cnt_q + CNT_W'(1);
    len_d      = period_end ? len_new : len_cur;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      len_cur <= CNT_W'(N_MIN);
      fb_tick <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      len_cur <= len_d;
      fb_tick <= period_end;
    end
  end
endmodule

// File: rtl/fracn_ref_prescaler.sv
module fracn_ref_prescaler (
  input  logic ref_clk,
  input  logic rst_n,
  input  logic pre_en,
  input  logic pre_sel,
  output logic pre_en_s,
  output logic ref_tick
);
  logic [1:0] meta_q, sync_q;
  logic [1:0] cnt_q, cnt_d, lim;
  logic       tick_d;

  assign pre_en_s = sync_q[1];

  always_comb begin
    lim    = sync_q[0] ? 2'd3 : 2'd1;
    cnt_d  = (!pre_en_s || cnt_q == lim) ? 2'd0 : cnt_q + 2'd1;
    tick_d = pre_en_s ? (cnt_q == lim) : 1'b1;
  end

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q   <= '0;
      sync_q   <= '0;
      cnt_q    <= '0;
      ref_tick <= 1'b0;
    end else begin
      meta_q   <= {pre_en, pre_sel};
      sync_q   <= meta_q;
      cnt_q    <= cnt_d;
      ref_tick <= tick_d;
    end
  end
endmodule

// File: rtl/fracn_fb_div.sv
module fracn_fb_div
  import fracn_fb_div_pkg::*;
#(
  parameter int FRAC_W = 22
) (
  input  logic              clk,
  input  logic              ref_clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [15:0]       wr_data,
  output logic              fb_tick,
  output logic              ref_tick,
  output logic [15:0]       cfg_q,
  output logic [FRAC_W-1:0] frac_q
);
  logic [1:0]        vrst_q, rrst_q;
  logic              rst_vco_n, rst_ref_n;
  cfg_t              cfg;
  logic              carry, period_end, sdm_en, pre_en_s;
  logic [FRAC_W-1:0] acc_q;
  logic [CNT_W-1:0]  len_cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vrst_q <= '0;
    else        vrst_q <= {vrst_q[0], 1'b1};
  end

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) rrst_q <= '0;
    else        rrst_q <= {rrst_q[0], 1'b1};
  end

  assign rst_vco_n = vrst_q[1];
  assign rst_ref_n = rrst_q[1];
  assign cfg       = cfg_t'(cfg_q);
  assign sdm_en    = cfg.frac_en;

  fracn_cfg_regs #(.FRAC_W(FRAC_W)) u_regs (
    .clk(clk), .rst_n(rst_vco_n), .wr_en(wr_en), .wr_data(wr_data),
    .ctrl_q(cfg_q), .frac_q(frac_q)
  );

  fracn_sdm_accum #(.FRAC_W(FRAC_W)) u_sdm (
    .clk(clk), .rst_n(rst_vco_n), .step_en(period_end & sdm_en),
    .frac_k(frac_q), .carry(carry), .acc_q(acc_q)
  );

  fracn_fb_counter u_cnt (
    .clk(clk), .rst_n(rst_vco_n), .ratio(cfg.ratio), .lf_div4(cfg.lf_div4),
    .stretch(sdm_en & carry), .period_end(period_end), .len_cur(len_cur),
    .fb_tick(fb_tick)
  );

  fracn_ref_prescaler u_pre (
    .ref_clk(ref_clk), .rst_n(rst_ref_n), .pre_en(cfg.pre_en),
    .pre_sel(cfg.pre_sel), .pre_en_s(pre_en_s), .ref_tick(ref_tick)
  );
endmodule

// File: rtl/fracn_fb_div_chk.sv
module fracn_fb_div_chk
  import fracn_fb_div_pkg::*;
#(
  parameter int FRAC_W = 22
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ref_clk,
  input logic              ref_rst_n,
  input logic              fb_tick,
  input logic              ref_tick,
  input logic              period_end,
  input logic              sdm_en,
  input logic              pre_en_s,
  input logic [CNT_W-1:0]  len_cur,
  input logic [FRAC_W-1:0] acc_q
);
  AST_TICK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    fb_tick |=> !fb_tick); // R7

  AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(len_cur) >= N_MIN) && (int'(len_cur) <= (N_MAX + 1) * LF_MUL)); // R3

  AST_LEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !period_end |=> $stable(len_cur)); // R6

  AST_ACC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !sdm_en |=> $stable(acc_q)); // R9

  AST_REF_BYPASS: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    !pre_en_s |=> ref_tick); // R8
endmodule

bind fracn_fb_div fracn_fb_div_chk #(.FRAC_W(FRAC_W)) u_chk (
  .clk(clk), .rst_n(rst_vco_n), .ref_clk(ref_clk), .ref_rst_n(rst_ref_n),
  .fb_tick(fb_tick), .ref_tick(ref_tick), .period_end(period_end),
  .sdm_en(sdm_en), .pre_en_s(pre_en_s), .len_cur(len_cur), .acc_q(acc_q)
);

// File: tb/fracn_fb_div_bench.sv
module fracn_fb_div_bench;
  localparam int FW = 10;

  logic          clk = 1'b0, ref_clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [15:0]   wr_data = '0;
  logic          fb_tick, ref_tick;
  logic [15:0]   cfg_q;
  logic [FW-1:0] frac_q;

  int n_run = 0, n_fail = 0, dbl = 0, last = 0, cyc = 0;
  bit have_last = 0, prev_tick = 0, live = 0;
  int    exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;
  always #3.5 ref_clk = ~ref_clk;

  fracn_fb_div #(.FRAC_W(FW)) u_fracn_fb_div (
    .clk(clk), .ref_clk(ref_clk), .rst_n(rst_n), .wr_en(wr_en),
    .wr_data(wr_data), .fb_tick(fb_tick), .ref_tick(ref_tick),
    .cfg_q(cfg_q), .frac_q(frac_q)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic logic [15:0] mk(int n, bit lf, bit sd, bit pe, bit ps, int pg, int d);
    return {4'(n), lf, sd, pe, ps, 1'b0, 3'(pg), 4'(d)};
  endfunction

  task automatic wr(input logic [15:0] v);
    @(negedge clk); wr_en = 1'b1; wr_data = v;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wait_tick();
    do @(negedge clk); while (!fb_tick);
  endtask

  task automatic expect_len(input int len, input int cnt, input string tag);
    #1;
    for (int i = 0; i < cnt; i++) begin exp_q.push_back(len); tag_q.push_back(tag); end
    while (exp_q.size() > 0) @(negedge clk);
  endtask

  task automatic ref_spacing(input int expv, input string tag);
    int n;
    repeat (10) @(negedge ref_clk);
    do @(negedge ref_clk); while (!ref_tick);
    for (int i = 0; i < 3; i++) begin
      n = 0;
      do begin @(negedge ref_clk); n++; end while (!ref_tick);
      chk(n == expv, tag, n, expv);
    end
  endtask

  // monitor: measures period lengths and pops expected ones
  always @(negedge clk) begin
    if (live) begin
      cyc++;
      if (fb_tick && prev_tick) dbl++;
      prev_tick = fb_tick;
      if (fb_tick) begin
        if (have_last && exp_q.size() > 0) begin
          int e; string t;
          e = exp_q.pop_front(); t = tag_q.pop_front();
          chk((cyc - last) == e, t, cyc - last, e);
        end
        last = cyc; have_last = 1;
      end
    end
  end

  initial begin
    #800000;
    n_fail++; n_run++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int tot, kv;
    repeat (4) @(negedge clk);
    chk(cfg_q == 16'h0, "R1 reset ctrl", int'(cfg_q), 0);
    chk(frac_q == '0, "R2 reset frac", int'(frac_q), 0);
    rst_n = 1'b1; live = 1;
    wait_tick();
    expect_len(5, 2, "R3 reset code 0 clamps to 5");

    wr(mk(7, 0, 0, 0, 0, 0, 0)); wait_tick();
    chk(cfg_q == 16'h7000, "R1 ctrl readback", int'(cfg_q), 'h7000);
    expect_len(7, 3, "R3 integer N=7");
    wr(mk(15, 0, 0, 0, 0, 0, 0)); wait_tick();
    expect_len(12, 2, "R3 code 15 clamps to 12");
    wr(mk(12, 1, 0, 0, 0, 0, 0)); wait_tick();
    expect_len(48, 2, "R5 N=12 with div4 gives 48");

    // load K = 0x23F over pages 0..2, integer mode: K must have no effect
    wr(mk(5, 0, 0, 0, 0, 0, 'hF));
    wr(mk(5, 0, 0, 0, 0, 1, 'h3));
    wr(mk(5, 0, 0, 0, 0, 2, 'h2)); wait_tick();
    chk(frac_q == 10'h23F, "R2 paged load", int'(frac_q), 'h23F);
    expect_len(5, 3, "R9 K ignored in integer mode");

    // mid-period write: running period keeps old length
    wait_tick();
    @(negedge clk);
    wr(mk(9, 0, 0, 0, 0, 2, 2));
    expect_len(5, 1, "R6 running period keeps old length");
    expect_len(9, 2, "R6 new length from next period");

    // fractional average over 2^FW periods
    wr(mk(7, 0, 1, 0, 0, 2, 2)); wait_tick(); wait_tick();
    kv = 'h23F; tot = 0;
    for (int p = 0; p < (1 << FW); p++) begin
      do begin @(negedge clk); tot++; end while (!fb_tick);
    end
    chk(tot == 7 * (1 << FW) + kv, "R4 fractional total", tot, 7 * (1 << FW) + kv);
    wr(mk(7, 1, 1, 0, 0, 2, 2)); wait_tick(); wait_tick();
    tot = 0;
    for (int p = 0; p < (1 << FW); p++) begin
      do begin @(negedge clk); tot++; end while (!fb_tick);
    end
    chk(tot == 4 * (7 * (1 << FW) + kv), "R5 R4 fractional with div4", tot, 4 * (7 * (1 << FW) + kv));

    // pages above K ignored; top page keeps low 2 bits
    wr(mk(7, 0, 0, 0, 0, 3, 'hF));
    chk(frac_q == 10'h23F, "R2 page 3 ignored", int'(frac_q), 'h23F);
    wr(mk(7, 0, 0, 0, 0, 7, 'hF));
    chk(frac_q == 10'h23F, "R2 page 7 ignored", int'(frac_q), 'h23F);
    wr(mk(7, 0, 0, 0, 0, 2, 'hF));
    chk(frac_q == 10'h33F, "R2 top page 2 bits", int'(frac_q), 'h33F);

    // reference prescaler
    ref_spacing(1, "R8 bypass");
    wr(mk(7, 0, 0, 1, 0, 2, 'hF));
    ref_spacing(2, "R8 divide by 2");
    wr(mk(7, 0, 0, 1, 1, 2, 'hF));
    ref_spacing(4, "R8 divide by 4");

    chk(dbl == 0, "R7 single-cycle fb_tick", dbl, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule